// File: doc/BRIEF.md
# Programmable Down-Counter Timer

A single countdown timer controlled through a word-addressed register port. Software stores a reload value, picks a counting mode (free-running, periodic or one-shot), a counter width of 16 or 32 bits and a tick divisor of 1, 16 or 256, and then sets the run bit. Every divided tick lowers the count by one. When the count reaches zero the block latches a raw event flag. The flag drives the interrupt output when the interrupt-enable bit is set.

There are two ways to change the reload value. An immediate load also copies the new value into the live count. A deferred load only updates the stored reload value, and the counter takes it up at its next wrap. In free-running mode the stored value is ignored and the counter wraps to the all-ones value of the selected width. Writes take effect on the clock edge. Reads are combinational from the read address. The active-low reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `down_timer`

## Requirements
- R1: After reset the control register reads 0x20 (only interrupt enable set), the count, reload value and flag read zero, and `irq` is low. The control bits are: [0] one-shot, [1] 32-bit width, [3:2] divisor, [5] interrupt enable, [6] periodic, [7] run.
- R2: The register is picked by byte-address bits [ADDR_W-1:2], and bits [1:0] are ignored. Word 0 is the immediate load, 1 the count, 2 control, 3 flag clear, 4 raw flag, 5 masked flag and 6 the deferred load. Every other word reads zero.
- R3: A write to word 0 stores the reload value and at once sets the count to that value, masked to the selected width. Reads of word 0 and of word 6 both return the stored reload value.
- R4: A write to word 6 stores the reload value and leaves the count alone. The new value enters the count at the next wrap.
- R5: In periodic mode (bit 6 set, bit 0 clear) each tick lowers the count by one. The tick that takes it from 1 to 0 sets the raw flag, and the tick that finds it at 0 reloads it from the stored value.
- R6: In one-shot mode (bit 0 set, whatever bit 6 holds) the tick that takes the count to 0 sets the flag and clears the run bit, and the count stays at 0.
- R7: In free-running mode (bits 0 and 6 clear) a tick at 0 wraps the count to 0xFFFF or 0xFFFFFFFF, according to bit 1, and ignores the stored reload value.
- R8: With bit 1 clear the counter works on 16 bits: loads are cut to their low 16 bits, the count reads back zero-extended, and the reload read returns all 32 stored bits.
- R9: Bits [3:2] select the tick divisor: 00 and 11 give 1, 01 gives 16 and 10 gives 256. The divider runs freely. A control write that changes the field restarts it, so the first tick comes 16 (or 256) clocks after that write.
- R10: While the run bit is clear the count holds its value.
- R11: Word 4 bit 0 returns the raw flag. Word 5 and the `irq` output both equal the raw flag ANDed with interrupt enable.
- R12: Any write to word 3 clears the raw flag. If a counter expiry happens in the same cycle, the flag stays set.
- R13: Writes to word 1 are ignored and do not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Masked interrupt level |

## Verification
The bound checker watches several rules on every cycle:
- an expiry sets the flag one cycle later;
- a clear without an expiry drops the flag, and a clear that meets an expiry loses to it;
- a one-shot expiry stops the counter;
- a stopped counter, or a write to the count word, leaves the count unchanged;
- free-running mode wraps from zero to all ones;
- the /16 tick never fires on two cycles in a row.

Only the bench scenarios can show the exact cycle counts: the period of load plus one, the 16-clock and 256-clock spacing after a divisor change, and a deferred load surfacing only after the wrap. The bench also covers the register map, 16-bit truncation, the reset values and the readback of the stored reload value.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Control byte; field positions are software-visible
  typedef struct packed {
    logic       run;       // [7]
    logic       periodic;  // [6]
    logic       ie;        // [5]
    logic       spare;     // [4]
    logic [1:0] pre;       // [3:2]
    logic       wide;      // [1]
    logic       oneshot;   // [0]
  } ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h20;

  localparam int unsigned W_LOAD   = 0;
  localparam int unsigned W_VALUE  = 1;
  localparam int unsigned W_CTRL   = 2;
  localparam int unsigned W_CLEAR  = 3;
  localparam int unsigned W_RAW    = 4;
  localparam int unsigned W_MASKED = 5;
  localparam int unsigned W_BGLOAD = 6;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SHIFT_A = 4,
  parameter int unsigned SHIFT_B = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       tick
);
  localparam logic [SHIFT_B-1:0] LAST_A = {{(SHIFT_B-SHIFT_A){1'b0}}, {SHIFT_A{1'b1}}};
  localparam logic [SHIFT_B-1:0] LAST_B = {SHIFT_B{1'b1}};

  logic [SHIFT_B-1:0] div_q, div_d, last;

  always_comb begin
    unique case (sel)
      2'b01:   last = LAST_A;
      2'b10:   last = LAST_B;
      default: last = '0;
    endcase
    tick  = (div_q == last);
    div_d = (restart || tick) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         oneshot,
  input  logic         periodic,
  input  logic         wide,
  input  logic [W-1:0] reload,
  input  logic         load_now,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value,
  output logic         expire,
  output logic         halt
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] cnt_q, cnt_d, mask, cur;
  logic         free_run;

  always_comb begin
    mask     = wide ? {W{1'b1}} : NMASK;
    cur      = cnt_q & mask;
    free_run = !oneshot && !periodic;
    cnt_d    = cnt_q;
    expire   = 1'b0;
    halt     = 1'b0;
    if (load_now) begin
      cnt_d = load_val & mask;
    end else if (run && tick) begin
      if (cur == '0) begin
        if (oneshot) halt = 1'b1;
        else         cnt_d = free_run ? mask : (reload & mask);
      end else if (cur == {{(W-1){1'b0}}, 1'b1}) begin
        cnt_d  = '0;
        expire = 1'b1;
        halt   = oneshot;
      end else begin
        cnt_d = cur - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign value = cur;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs import timer_pkg::*; #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic [W-1:0]  value,
  input  logic          expire,
  input  logic          halt,
  output ctrl_t         ctrl,
  output logic [W-1:0]  reload,
  output logic          flag,
  output logic          load_now,
  output logic          pre_restart
);
  localparam int unsigned WW = AW - 2;

  logic [WW-1:0] wword, rword;
  logic          wr_load, wr_ctrl, wr_clr, wr_bg;
  ctrl_t         ctrl_q, ctrl_d, ctrl_new;
  logic [W-1:0]  reload_q, reload_d;
  logic          flag_q, flag_d;
  logic [1:0]    unused_lsb;

  assign wword      = wr_addr[AW-1:2];
  assign rword      = rd_addr[AW-1:2];
  assign unused_lsb = wr_addr[1:0] ^ rd_addr[1:0];
  assign ctrl_new   = ctrl_t'(wr_data[7:0]);

  always_comb begin
    wr_load = wr_en && (wword == WW'(W_LOAD));
    wr_ctrl = wr_en && (wword == WW'(W_CTRL));
    wr_clr  = wr_en && (wword == WW'(W_CLEAR));
    wr_bg   = wr_en && (wword == WW'(W_BGLOAD));
  end

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)   ctrl_d = ctrl_new;
    else if (halt) ctrl_d.run = 1'b0;

    reload_d = reload_q;
    if (wr_load || wr_bg) reload_d = wr_data;

    flag_d = flag_q;
    if (expire)      flag_d = 1'b1;
    else if (wr_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= ctrl_t'(CTRL_RST);
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      flag_q   <= flag_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (rword)
      WW'(W_LOAD), WW'(W_BGLOAD): rd_data = reload_q;
      WW'(W_VALUE):               rd_data = value;
      WW'(W_CTRL):                rd_data = W'(ctrl_q);
      WW'(W_RAW):                 rd_data = W'(flag_q);
      WW'(W_MASKED):              rd_data = W'(flag_q && ctrl_q.ie);
      default:                    rd_data = '0;
    endcase
  end

  assign ctrl        = ctrl_q;
  assign reload      = reload_q;
  assign flag        = flag_q;
  assign load_now    = wr_load;
  assign pre_restart = wr_ctrl && (ctrl_new.pre != ctrl_q.pre);
endmodule

// File: rtl/down_timer.sv
module down_timer import timer_pkg::*; #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PRE_A    = 4,
  parameter int unsigned PRE_B    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [1:0]        rst_pipe_q;
  logic              core_rst_n;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, value;
  logic              flag, load_now, pre_restart, tick, expire, halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  tmr_prescaler #(.SHIFT_A(PRE_A), .SHIFT_B(PRE_B)) u_pre (
    .clk(clk), .rst_n(core_rst_n), .sel(ctrl.pre),
    .restart(pre_restart), .tick(tick)
  );

  tmr_counter #(.W(DATA_W), .NW(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(core_rst_n), .tick(tick), .run(ctrl.run),
    .oneshot(ctrl.oneshot), .periodic(ctrl.periodic), .wide(ctrl.wide),
    .reload(reload), .load_now(load_now), .load_val(wr_data),
    .value(value), .expire(expire), .halt(halt)
  );

  tmr_regs #(.W(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .value(value), .expire(expire), .halt(halt), .ctrl(ctrl),
    .reload(reload), .flag(flag), .load_now(load_now),
    .pre_restart(pre_restart)
  );

  assign irq = flag && ctrl.ie;
endmodule

// File: rtl/down_timer_chk.sv
module down_timer_chk import timer_pkg::*; #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned ADDR_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input ctrl_t             ctrl,
  input logic              flag,
  input logic              expire,
  input logic              tick,
  input logic [DATA_W-1:0] value
);
  localparam int unsigned WW = ADDR_W - 2;
  localparam logic [DATA_W-1:0] NMASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic wr_clr, wr_ctl, wr_val;
  assign wr_clr = wr_en && (wr_addr[ADDR_W-1:2] == WW'(W_CLEAR));
  assign wr_ctl = wr_en && (wr_addr[ADDR_W-1:2] == WW'(W_CTRL));
  assign wr_val = wr_en && (wr_addr[ADDR_W-1:2] == WW'(W_VALUE));

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !expire |=> !flag);
  // R12
  expiry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && expire |=> flag);
  // R6
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctrl.oneshot && !wr_ctl |=> !ctrl.run);
  // R13
  value_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val && !(ctrl.run && tick) |=> $stable(value));
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run && !wr_en |=> $stable(value));
  // R7
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ctrl.run && !ctrl.oneshot && !ctrl.periodic && (value == '0) && !wr_en
    |=> value == (ctrl.wide ? {DATA_W{1'b1}} : NMASK));
  // R9
  div16_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (ctrl.pre == 2'b01) && !wr_en |=> !tick);
endmodule

bind down_timer down_timer_chk #(
  .DATA_W(DATA_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctrl(ctrl), .flag(flag), .expire(expire), .tick(tick), .value(value)
);

// File: tb/tb_down_timer.sv
module tb_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  down_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // op: 0 write, 1 read-compare, 2 idle cycles (data = count)
  localparam int NV = 37;
  localparam logic [77:0] VEC [NV] = '{
    {2'd1, 4'd1,  8'h08, 32'h0,   32'h20},  // R1 control reset
    {2'd1, 4'd1,  8'h04, 32'h0,   32'h0},   // R1 count reset
    {2'd1, 4'd1,  8'h10, 32'h0,   32'h0},   // R1 flag reset
    {2'd0, 4'd3,  8'h00, 32'h5,   32'h0},
    {2'd1, 4'd3,  8'h04, 32'h0,   32'h5},   // R3 immediate count
    {2'd1, 4'd3,  8'h00, 32'h0,   32'h5},   // R3
    {2'd1, 4'd3,  8'h18, 32'h0,   32'h5},   // R3 alias read
    {2'd0, 4'd13, 8'h04, 32'h1234,32'h0},
    {2'd1, 4'd13, 8'h04, 32'h0,   32'h5},   // R13
    {2'd1, 4'd2,  8'h0B, 32'h0,   32'h20},  // R2 low bits ignored
    {2'd1, 4'd2,  8'h1C, 32'h0,   32'h0},   // R2 undefined word
    {2'd0, 4'd5,  8'h08, 32'hE0,  32'h0},
    {2'd2, 4'd5,  8'h00, 32'd3,   32'h0},
    {2'd1, 4'd5,  8'h04, 32'h0,   32'h2},   // R5
    {2'd2, 4'd5,  8'h00, 32'd2,   32'h0},
    {2'd1, 4'd11, 8'h10, 32'h0,   32'h1},   // R11 raw
    {2'd1, 4'd11, 8'h14, 32'h0,   32'h1},   // R11 masked
    {2'd2, 4'd5,  8'h00, 32'd1,   32'h0},
    {2'd1, 4'd5,  8'h04, 32'h0,   32'h5},   // R5 reload
    {2'd0, 4'd12, 8'h0C, 32'h0,   32'h0},
    {2'd1, 4'd12, 8'h10, 32'h0,   32'h0},   // R12
    {2'd1, 4'd5,  8'h04, 32'h0,   32'h4},   // R5
    {2'd0, 4'd4,  8'h18, 32'h100, 32'h0},
    {2'd1, 4'd4,  8'h04, 32'h0,   32'h3},   // R4 count untouched
    {2'd1, 4'd4,  8'h00, 32'h0,   32'h100}, // R4
    {2'd2, 4'd4,  8'h00, 32'd3,   32'h0},
    {2'd1, 4'd4,  8'h04, 32'h0,   32'h0},   // R4
    {2'd1, 4'd5,  8'h10, 32'h0,   32'h1},   // R5
    {2'd2, 4'd4,  8'h00, 32'd1,   32'h0},
    {2'd1, 4'd4,  8'h04, 32'h0,   32'h100}, // R4 picked up at wrap
    {2'd0, 4'd10, 8'h08, 32'h20,  32'h0},
    {2'd2, 4'd10, 8'h00, 32'd3,   32'h0},
    {2'd1, 4'd10, 8'h04, 32'h0,   32'hFF},  // R10 hold
    {2'd0, 4'd11, 8'h08, 32'h00,  32'h0},
    {2'd1, 4'd11, 8'h14, 32'h0,   32'h0},   // R11 masked off
    {2'd1, 4'd11, 8'h10, 32'h0,   32'h1},   // R11 raw kept
    {2'd1, 4'd1,  8'h08, 32'h0,   32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      case (v[77:76])
        2'd0: wr(v[71:64], v[63:32]);
        2'd1: rd($sformatf("R%0d vec %0d", v[75:72], i), v[71:64], v[31:0]);
        default: idle(int'(v[63:32]));
      endcase
    end

    // R6 one-shot
    wr(8'h0C, 0);
    wr(8'h00, 32'h2);
    wr(8'h08, 32'hE3);
    idle(3);
    rd("R6 count", 8'h04, 32'h0);
    rd("R6 run cleared", 8'h08, 32'h63);
    chk("R11 irq", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'hDEAD);
    chk("R12 irq cleared", {31'b0, irq}, 32'h0);

    // R7 / R8 free-running, 16-bit
    wr(8'h00, 32'h1);
    wr(8'h08, 32'hA0);
    idle(2);
    rd("R7 wrap 16", 8'h04, 32'hFFFF);
    wr(8'h08, 32'h22);
    wr(8'h00, 32'h1);
    wr(8'h08, 32'hA2);
    idle(2);
    rd("R7 wrap 32", 8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h20);
    wr(8'h00, 32'h12345);
    rd("R8 truncated", 8'h04, 32'h2345);
    rd("R8 reload full", 8'h00, 32'h12345);

    // R12 clear meets expiry
    wr(8'h00, 32'h3);
    wr(8'h0C, 0);
    wr(8'h08, 32'hE0);
    idle(2);
    wr(8'h0C, 0);
    rd("R12 expiry wins", 8'h10, 32'h1);

    // R9 divide by 16
    wr(8'h08, 32'h20);
    wr(8'h00, 32'h4);
    wr(8'h08, 32'hC4);
    idle(15);
    rd("R9 /16 early", 8'h04, 32'h4);
    idle(1);
    rd("R9 /16 tick", 8'h04, 32'h3);
    // R9 divide by 256
    wr(8'h08, 32'h04);
    wr(8'h00, 32'h4);
    wr(8'h08, 32'hC8);
    idle(255);
    rd("R9 /256 early", 8'h04, 32'h4);
    idle(1);
    rd("R9 /256 tick", 8'h04, 32'h3);

    // R1 reset in mid-run
    wr(8'h08, 32'hE0);
    rst_n = 1'b0;
    #1;
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    idle(2);
    rst_n = 1'b1;
    idle(3);
    rd("R1 ctrl after reset", 8'h08, 32'h20);
    rd("R1 load after reset", 8'h00, 32'h0);

    finish_run();
  end
endmodule